// File: doc/BRIEF.md
# SDRAM Mode Register and Burst Timing Model

This block is a cycle-accurate behavioural model of the data path of a single SDRAM device. It covers the mode register and the timing of read and write bursts. A controller drives a single-rate command code with an address word and write data. The model answers with read data, a bus-drive enable and a strobe that marks each captured write beat. A small internal column store holds the data, so bursts that were written can be read back in the programmed order.

The mode register holds four settings: the read latency (2 or 3 clocks), the burst length (1, 2, 4 or 8 beats), the column ordering inside a burst (sequential or interleaved) and a write policy. Under that write policy, writes move a single location while reads keep the full burst. A controller uses the model to check that its sampling edges, its bus turnaround and its command spacing match what a real device would accept.

Top module: `sdram_burst_model`

## Requirements
- R1: After reset the settings are latency 2, burst length 1, sequential order and burst writes. `dq_oe`, `dq_out`, `wr_stb` and `mode_err` are 0, and every stored column reads as 0.
- R2: For a READ (`cmd`=2'b10) registered at edge n with latency m, beat 0 is on `dq_out` at edge n+m. Beat i follows at edge n+m+i, and the READ takes its start column from `addr[COL_W-1:0]`.
- R3: `dq_oe` is high at edges n+m-1 through n+m+BL-1 and low at edge n+m+BL. While `dq_oe` is low, or no beat is valid, `dq_out` is 0, and NOP (`cmd`=2'b00) cycles never drive.
- R4: A set-mode command (`cmd`=2'b01) reads its field from `addr[9:0]`: burst code [2:0], order [3], latency code [6:4], operating code [8:7], write policy [9]. The field is legal only when [8:7]=00, [6:4] is 010 or 011, and [2] is 0. An illegal field leaves every setting unchanged and raises `mode_err` for exactly one cycle, seen at the edge after the command.
- R5: Burst codes 000, 001, 010 and 011 select 1, 2, 4 and 8 beats. Latency codes 010 and 011 select 2 and 3 clocks.
- R6: With order bit 0, beat i addresses the column (start + i) mod BL inside the BL-aligned block that holds the start column.
- R7: With order bit 1, beat i addresses the column start XOR i inside the same aligned block.
- R8: With write policy 0, a WRITE (`cmd`=2'b11) stores `dq_in` at its own edge n and at the next BL-1 edges, in the order of R6/R7. `wr_stb` is high at the edge after each capture.
- R9: With write policy 1, a WRITE stores only the beat at edge n, into the start column, while READs still return BL beats.
- R10: While a burst is in progress, every non-NOP command is ignored. A command is next accepted at edge n+m+BL after a READ, or at edge n+WL after a WRITE of WL beats.
- R11: An accepted set-mode command governs the command registered at the very next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 2 | Command code: 00 NOP, 01 set mode, 10 read, 11 write |
| addr | input | ADDR_W | Mode field on set-mode, start column on read and write |
| dq_in | input | DATA_W | Write data, sampled on each write beat |
| dq_out | output | DATA_W | Read data, 0 when no beat is valid |
| dq_oe | output | 1 | High while the model would drive the data bus |
| wr_stb | output | 1 | High at the edge after each captured write beat |
| mode_err | output | 1 | One-cycle flag for a rejected set-mode field |

## Verification
The bench builds the model at its defaults: 16-bit data, a 16-column store and a 10-bit address. With 16 columns, an 8-beat burst can start partway through a block and wrap, and column bit 3 lies outside the burst block, so both wrap orders and the aligned-block boundary can be observed. The reference model tracks the settings, the stored words and the earliest edge that accepts a command. Against these it predicts the enable, data, strobe and error flag for every edge. That prediction covers commands issued exactly at, and one cycle before, the end of a busy window.

// File: rtl/sdram_mode_pkg.sv
`timescale 1ns/1ps
package sdram_mode_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE    = 2'b00,
        CMD_SETMODE = 2'b01,
        CMD_READ    = 2'b10,
        CMD_WRITE   = 2'b11
    } cmd_e;

    localparam int FIELD_W = 10;

    typedef struct packed {
        logic       single_wr;
        logic [1:0] lat;
        logic       ilv;
        logic [3:0] blen;
    } mode_t;

    localparam mode_t MODE_RESET = '{single_wr: 1'b0, lat: 2'd2, ilv: 1'b0, blen: 4'd1};

    // legal field: normal operating code, latency 2 or 3, burst code below 4
    function automatic logic field_ok(input logic [FIELD_W-1:0] f);
        return (f[8:7] == 2'b00) && (f[6:4] == 3'b010 || f[6:4] == 3'b011) && (f[2] == 1'b0);
    endfunction

    function automatic mode_t field_decode(input logic [FIELD_W-1:0] f);
        mode_t m;
        m.single_wr = f[9];
        m.lat       = (f[6:4] == 3'b011) ? 2'd3 : 2'd2;
        m.ilv       = f[3];
        m.blen      = 4'd1 << f[1:0];
        return m;
    endfunction

    // low three column bits of a beat; blen_lo is the burst length modulo 8
    function automatic logic [2:0] beat_low(input logic [2:0] start, input logic [2:0] beat,
                                            input logic [2:0] blen_lo, input logic ilv);
        logic [2:0] mask;
        logic [2:0] mix;
        mask = blen_lo - 3'd1;
        mix  = ilv ? (start ^ beat) : (start + beat);
        return (start & ~mask) | (mix & mask);
    endfunction

endpackage

// File: rtl/sdram_mode_reg.sv
`timescale 1ns/1ps
module sdram_mode_reg
    import sdram_mode_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [FIELD_W-1:0] field,
    output mode_t              mode,
    output logic               err
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= MODE_RESET;
            err  <= 1'b0;
        end else begin
            err <= load && !field_ok(field);
            if (load && field_ok(field))
                mode <= field_decode(field);
        end
    end

    assert_bad_field_keeps_mode_R4: assert property (@(posedge clk) disable iff (rst)
        err |-> $stable(mode));

    assert_err_single_cycle_R4: assert property (@(posedge clk) disable iff (rst)
        (err && !$past(load)) |-> 1'b0);

    assert_blen_power_R5: assert property (@(posedge clk) disable iff (rst)
        ($countones(mode.blen) == 1) && (mode.lat == 2'd2 || mode.lat == 2'd3));

endmodule

// File: rtl/sdram_col_store.sv
`timescale 1ns/1ps
module sdram_col_store #(
    parameter int COL_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [COL_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [COL_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << COL_W;

    logic [DATA_W-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < DEPTH; w++)
                words[w] <= '0;
        end else if (we) begin
            words[waddr] <= wdata;
        end
    end

    assign rdata = words[raddr];

endmodule

// File: rtl/sdram_rd_ctl.sv
`timescale 1ns/1ps
module sdram_rd_ctl
    import sdram_mode_pkg::*;
#(
    parameter int COL_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [COL_W-1:0]  start_col,
    input  logic [1:0]        lat,
    input  logic [3:0]        blen,
    input  logic              ilv,
    input  logic [DATA_W-1:0] rdata,
    output logic [COL_W-1:0]  raddr,
    output logic              oe,
    output logic [DATA_W-1:0] dout,
    output logic              busy
);

    localparam int K_W = 5;

    logic             act_q;
    logic [K_W-1:0]   t_q;
    logic [COL_W-1:0] col_q;
    logic             oe_q;
    logic             dv_q;
    logic [DATA_W-1:0] dout_q;

    logic             live;
    logic [K_W-1:0]   k_now;
    logic [K_W-1:0]   lat_k;
    logic [K_W-1:0]   span_k;
    logic [2:0]       idx;
    logic             oe_d;
    logic             beat_d;
    logic             act_d;
    logic [COL_W-1:0] base_col;
    logic [2:0]       low;

    // k_now counts edges since the READ edge (0 on that edge itself)
    always_comb begin
        lat_k    = K_W'(lat);
        span_k   = K_W'(lat) + K_W'(blen);
        live     = start || act_q;
        k_now    = start ? '0 : t_q + K_W'(1);
        oe_d     = live && (k_now + K_W'(2) >= lat_k) && (k_now + K_W'(2) <= span_k);
        beat_d   = live && (k_now + K_W'(1) >= lat_k) && (k_now + K_W'(2) <= span_k);
        act_d    = live && (k_now + K_W'(1) < span_k);
        idx      = k_now[2:0] + 3'd1 - {1'b0, lat};
        base_col = start ? start_col : col_q;
        low      = beat_low(base_col[2:0], idx, blen[2:0], ilv);
    end

    generate
        if (COL_W > 3) begin : g_wide
            assign raddr = {base_col[COL_W-1:3], low};
        end else begin : g_narrow
            assign raddr = low[COL_W-1:0];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= 1'b0;
            t_q    <= '0;
            col_q  <= '0;
            oe_q   <= 1'b0;
            dv_q   <= 1'b0;
            dout_q <= '0;
        end else begin
            act_q  <= act_d;
            t_q    <= k_now;
            oe_q   <= oe_d;
            dv_q   <= beat_d;
            dout_q <= beat_d ? rdata : '0;
            if (start)
                col_q <= start_col;
        end
    end

    assign oe   = oe_q;
    assign dout = dout_q;
    assign busy = act_q;

    assert_oe_leads_data_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(dv_q) |-> $past(oe_q));

    assert_data_inside_oe_R3: assert property (@(posedge clk) disable iff (rst)
        dv_q |-> oe_q);

    assert_oe_drops_after_beat_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(oe_q) |-> $past(dv_q));

    assert_first_beat_lat2_R2: assert property (@(posedge clk) disable iff (rst)
        ($rose(dv_q) && lat == 2'd2) |-> $past(start, 2));

    assert_first_beat_lat3_R2: assert property (@(posedge clk) disable iff (rst)
        ($rose(dv_q) && lat == 2'd3) |-> $past(start, 3));

endmodule

// File: rtl/sdram_wr_ctl.sv
`timescale 1ns/1ps
module sdram_wr_ctl
    import sdram_mode_pkg::*;
#(
    parameter int COL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  logic             single_wr,
    input  logic [3:0]       blen,
    input  logic             ilv,
    output logic             we,
    output logic [COL_W-1:0] waddr,
    output logic             stb,
    output logic             busy
);

    logic             act_q;
    logic [3:0]       i_q;
    logic [COL_W-1:0] col_q;
    logic [3:0]       wl_q;
    logic             stb_q;

    logic [3:0]       wl_now;
    logic [3:0]       beat;
    logic [COL_W-1:0] base_col;
    logic             act_d;
    logic [2:0]       low;

    always_comb begin
        wl_now   = start ? (single_wr ? 4'd1 : blen) : wl_q;
        beat     = start ? 4'd0 : i_q;
        base_col = start ? start_col : col_q;
        we       = start || act_q;
        act_d    = we && (beat + 4'd1 < wl_now);
        low      = beat_low(base_col[2:0], beat[2:0], wl_now[2:0], ilv);
    end

    generate
        if (COL_W > 3) begin : g_wide
            assign waddr = {base_col[COL_W-1:3], low};
        end else begin : g_narrow
            assign waddr = low[COL_W-1:0];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= 1'b0;
            i_q   <= '0;
            col_q <= '0;
            wl_q  <= 4'd1;
            stb_q <= 1'b0;
        end else begin
            act_q <= act_d;
            i_q   <= beat + 4'd1;
            stb_q <= we;
            if (start) begin
                col_q <= start_col;
                wl_q  <= wl_now;
            end
        end
    end

    assign stb  = stb_q;
    assign busy = act_q;

    assert_single_no_tail_R9: assert property (@(posedge clk) disable iff (rst)
        (start && single_wr) |=> !act_q);

    assert_burst_count_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(act_q) |-> (i_q == wl_q));

endmodule

// File: rtl/sdram_burst_model.sv
`timescale 1ns/1ps
module sdram_burst_model
    import sdram_mode_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int COL_W  = 4,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cmd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              wr_stb,
    output logic              mode_err
);

    cmd_e             cmd_v;
    mode_t            mode_q;
    logic             rd_busy;
    logic             wr_busy;
    logic             busy;
    logic             rd_go;
    logic             wr_go;
    logic             set_go;
    logic             we;
    logic [COL_W-1:0] waddr;
    logic [COL_W-1:0] raddr;
    logic [DATA_W-1:0] rdata;

    assign cmd_v  = cmd_e'(cmd);
    assign busy   = rd_busy || wr_busy;
    assign rd_go  = (cmd_v == CMD_READ)    && !busy;
    assign wr_go  = (cmd_v == CMD_WRITE)   && !busy;
    assign set_go = (cmd_v == CMD_SETMODE) && !busy;

    sdram_mode_reg u_mode (
        .clk   (clk),
        .rst   (rst),
        .load  (set_go),
        .field (addr[FIELD_W-1:0]),
        .mode  (mode_q),
        .err   (mode_err)
    );

    sdram_col_store #(.COL_W(COL_W), .DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (we),
        .waddr (waddr),
        .wdata (dq_in),
        .raddr (raddr),
        .rdata (rdata)
    );

    sdram_rd_ctl #(.COL_W(COL_W), .DATA_W(DATA_W)) u_rd (
        .clk       (clk),
        .rst       (rst),
        .start     (rd_go),
        .start_col (addr[COL_W-1:0]),
        .lat       (mode_q.lat),
        .blen      (mode_q.blen),
        .ilv       (mode_q.ilv),
        .rdata     (rdata),
        .raddr     (raddr),
        .oe        (dq_oe),
        .dout      (dq_out),
        .busy      (rd_busy)
    );

    sdram_wr_ctl #(.COL_W(COL_W)) u_wr (
        .clk       (clk),
        .rst       (rst),
        .start     (wr_go),
        .start_col (addr[COL_W-1:0]),
        .single_wr (mode_q.single_wr),
        .blen      (mode_q.blen),
        .ilv       (mode_q.ilv),
        .we        (we),
        .waddr     (waddr),
        .stb       (wr_stb),
        .busy      (wr_busy)
    );

    assert_setmode_blocked_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd_v == CMD_SETMODE) |=> $stable(mode_q));

    assert_one_burst_kind_R10: assert property (@(posedge clk) disable iff (rst)
        !(rd_busy && wr_busy));

    assert_no_drive_while_writing_R3: assert property (@(posedge clk) disable iff (rst)
        wr_busy |-> !dq_oe);

endmodule

// File: tb/sdram_burst_model_test.sv
`timescale 1ns/1ps
module sdram_burst_model_test;

    localparam int DW   = 16;
    localparam int CW   = 4;
    localparam int AW   = 10;
    localparam int NCYC = 4096;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    cmd = 2'b00;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic          dq_oe;
    logic          wr_stb;
    logic          mode_err;

    always #4 clk = ~clk;   // 125 MHz

    sdram_burst_model #(.DATA_W(DW), .COL_W(CW), .ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .cmd(cmd), .addr(addr), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe), .wr_stb(wr_stb), .mode_err(mode_err)
    );

    int    cyc = 0;
    int    total = 0;
    int    bad = 0;
    bit    done = 0;
    string req = "R1";

    int e_oe [NCYC];
    int e_dq [NCYC];
    int e_stb[NCYC];
    int e_err[NCYC];
    int mem  [16];
    int m_lat = 2, m_bl = 1, m_ilv = 0, m_single = 0, free_at = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int colof(int start, int i, int bl, int ilv);
        int base;
        int off;
        base = start - (start % bl);
        off  = start - base;
        if (ilv != 0) return base + (off ^ i);
        return base + ((off + i) % bl);
    endfunction

    task automatic check(input string what, input logic [31:0] got, input int exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s edge %0d: got %0h expected %0h", req, what, cyc, got, exp);
        end
    endtask

    task automatic model(input int n, input int c, input int a, input int d);
        int wl;
        if (c == 0 || n < free_at) return;
        if (c == 1) begin
            if (((a >> 7) & 3) == 0 && (((a >> 4) & 7) == 2 || ((a >> 4) & 7) == 3) && (a & 7) < 4) begin
                m_lat    = (a >> 4) & 7;
                m_bl     = 1 << (a & 3);
                m_ilv    = (a >> 3) & 1;
                m_single = (a >> 9) & 1;
            end else begin
                e_err[n] = 1;
            end
        end else if (c == 2) begin
            for (int e = n + m_lat - 2; e <= n + m_lat + m_bl - 2; e++) e_oe[e] = 1;
            for (int i = 0; i < m_bl; i++)
                e_dq[n + m_lat - 1 + i] = mem[colof(a & 15, i, m_bl, m_ilv)];
            free_at = n + m_lat + m_bl;
        end else begin
            wl = (m_single != 0) ? 1 : m_bl;
            for (int j = 0; j < wl; j++) begin
                mem[colof(a & 15, j, wl, m_ilv)] = (d + j) & 16'hffff;
                e_stb[n + j] = 1;
            end
            free_at = n + wl;
        end
    endtask

    task automatic step(input int c, input int a, input int d);
        @(negedge clk);
        if (cyc >= 1) begin
            check("dq_oe",    {31'b0, dq_oe},    e_oe[cyc]);
            check("dq_out",   {16'b0, dq_out},   e_dq[cyc]);
            check("wr_stb",   {31'b0, wr_stb},   e_stb[cyc]);
            check("mode_err", {31'b0, mode_err}, e_err[cyc]);
        end
        cmd   = c[1:0];
        addr  = a[AW-1:0];
        dq_in = d[DW-1:0];
        if (!rst) model(cyc + 1, c, a, d);
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) step(0, 0, 0);
    endtask

    task automatic ld(input int f);  step(1, f, 0);  endtask
    task automatic rd(input int col); step(2, col, 0); endtask

    task automatic wr(input int col, input int base);
        step(3, col, base);
        for (int j = 1; j < 8; j++) step(0, 0, base + j);
    endtask

    initial begin
        for (int i = 0; i < NCYC; i++) begin
            e_oe[i] = 0; e_dq[i] = 0; e_stb[i] = 0; e_err[i] = 0;
        end
        for (int i = 0; i < 16; i++) mem[i] = 0;

        // R1: reset values, then a read with the reset settings
        req = "R1";
        idle(3);
        rst = 1'b0;
        idle(2);
        rd(5);
        idle(4);

        // R8: burst write, latency 3, length 4, sequential
        req = "R8";
        ld(12'h032);
        wr(6, 16'h00a0);
        // R6: sequential wrap inside the aligned block (6,7,4,5)
        req = "R6";
        rd(6);
        idle(8);

        // R2: same data with latency 2
        req = "R2";
        ld(12'h022);
        rd(6);
        idle(7);

        // R7: interleaved, length 8
        req = "R7";
        ld(12'h02b);
        wr(3, 16'h0100);
        rd(5);
        idle(12);

        // R5: length 2 with latency 3, then length 1
        req = "R5";
        ld(12'h031);
        rd(1);
        idle(6);
        ld(12'h020);
        rd(6);
        idle(4);

        // R4: illegal fields leave the settings at latency 2, length 1
        req = "R4";
        ld(12'h0b2);
        ld(12'h012);
        ld(12'h034);
        ld(12'h072);
        rd(7);
        idle(4);

        // R9: single-location writes, reads keep length 4
        req = "R9";
        ld(12'h232);
        wr(9, 16'h0300);
        rd(8);
        idle(8);

        // R10: commands during a read burst are ignored
        req = "R10";
        ld(12'h032);
        rd(4);
        ld(12'h020);
        step(3, 0, 16'h0bad);
        rd(0);
        idle(8);
        rd(4);
        idle(8);
        // R10: commands during a write burst are ignored
        step(3, 2, 16'h0400);
        step(2, 0, 16'h0401);
        step(1, 12'h020, 16'h0402);
        step(0, 0, 16'h0403);
        rd(2);
        idle(8);

        // R11: a new setting governs the next edge; boundary of the busy window
        req = "R11";
        ld(12'h020);
        rd(6);
        idle(1);
        rd(5);
        rd(7);
        idle(4);
        ld(12'h031);
        rd(2);
        idle(6);

        // R3: long burst, enable window around 8 beats
        req = "R3";
        ld(12'h033);
        rd(0);
        idle(14);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1600000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog %s: got running expected finished", req);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule